// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block sits between a PWM period/duty generator and the two gate drivers of a half-bridge. It turns a single PWM level into two complementary drives. `drv_high` is for the upper switch and follows a high PWM level. `drv_low` is for the lower switch and follows a low PWM level.

Switching off happens at once. Switching on is held back by a programmable dead-band, so the switch being released has time to stop conducting before its partner starts. The dead-band is counted in units of the `unit_tick` strobe. The surrounding chip raises that strobe for one clock in every four, which makes one unit equal to one instruction cycle of four oscillator clocks.

The dead-band length is a 7-bit value loaded through a plain write strobe and readable on `dly_value`. A value of zero gives plain complementary outputs. The block carries only control-level pins and no data stream, so it has no valid/ready interface and no back-pressure.

Top module: `hbdb_gen`

## Requirements
- R1: While `rst_n` is low, `drv_high`, `drv_low` and `dly_value` are all 0. The first clock edge after reset release treats the present `pwm_in` level as a fresh transition.
- R2: `drv_high` and `drv_low` are never 1 in the same cycle.
- R3: An output turns off on the first clock edge that samples `pwm_in` at the level opposite to its own. `drv_high` is active for `pwm_in`=1 and `drv_low` for `pwm_in`=0.
- R4: A transition edge is one where the sampled `pwm_in` differs from the previous sample. For a transition edge with `dly_value`=D (D from 1 to 127), the output for the new level turns on at the edge that samples the D-th high `unit_tick` after the transition edge. A tick sampled on the transition edge itself is not counted.
- R5: One delay unit is one `unit_tick` pulse. With the tick high one clock in four, D units last 4·D clocks. Ticks advance only a pending turn-on.
- R6: When `dly_value` is 0 at a transition edge, both outputs take their new values on that edge, as exact complements with no gap.
- R7: If `pwm_in` changes again before a pending turn-on expires, that turn-on is dropped and a new count starts for the other output. A transition on the same edge as the expiring tick wins.
- R8: A delay written while a count is running leaves that count unchanged. It applies from the next transition.
- R9: `dly_wr`=1 at a clock edge loads `dly_wdata[6:0]` into `dly_value`, visible after that edge. While `dly_wr` is 0, `dly_value` holds its value whatever `dly_wdata` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw PWM level from the period/duty generator |
| unit_tick | input | 1 | One-clock strobe marking each delay unit |
| dly_wr | input | 1 | Load strobe for the dead-band value |
| dly_wdata | input | 7 | Dead-band value in units, 0 to 127 |
| dly_value | output | 7 | Dead-band value currently held |
| drv_high | output | 1 | Upper switch drive, active high |
| drv_low | output | 1 | Lower switch drive, active high |

## Verification
The main function is driven with PWM toggles at a zero delay, which isolates the direct complementary path. It is then driven at delays of 1, 2, 5 and 127 units with hold times longer than the delay, which measures the exact turn-on edge at both ends of the count range.

Hold times shorter than the delay, and hold times equal to it, separate a correct cancel from a late activation. The equal case also shows that a transition beats an expiring tick on the same edge.

A delay write in the middle of a running count tells apart latching at the transition from live use of the register. A data change without a write strobe shows that the held value is not disturbed.

// File: rtl/hbdb_pkg.sv
package hbdb_pkg;
  localparam int LEGS     = 2;
  localparam int LEG_HIGH = 0;
  localparam int LEG_LOW  = 1;

  // A strobe plus the PWM level it refers to.
  typedef struct packed {
    logic strobe;
    logic level;
  } pwm_evt_t;

  // Level of pwm_in at which a given leg conducts.
  function automatic logic leg_active_level(int leg);
    return (leg == LEG_HIGH) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/hbdb_edge_detect.sv
module hbdb_edge_detect
  import hbdb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwm_in,
  output pwm_evt_t evt
);
  logic pwm_q;
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      primed <= 1'b0;
    end else begin
      pwm_q  <= pwm_in;
      primed <= 1'b1;
    end
  end

  // The first sampled edge after reset counts as a transition.
  assign evt.strobe = !primed || (pwm_in != pwm_q);
  assign evt.level  = pwm_in;
endmodule

// File: rtl/hbdb_delay_cfg.sv
module hbdb_delay_cfg #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DLY_W-1:0] wdata,
  output logic [DLY_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= '0;
    else if (wr) value <= wdata;
  end
endmodule

// File: rtl/hbdb_dead_timer.sv
module hbdb_dead_timer
  import hbdb_pkg::*;
#(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwm_evt_t         evt,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output pwm_evt_t         fire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;
  logic             pending;
  logic             tgt;
  logic             zero_load;
  logic             expire;

  assign zero_load = (load_val == '0);
  // A new transition on the same edge overrides expiry.
  assign expire    = pending && tick && (cnt == ONE) && !evt.strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      tgt     <= 1'b0;
    end else if (evt.strobe) begin
      cnt     <= load_val;
      pending <= !zero_load;
      tgt     <= evt.level;
    end else if (pending && tick) begin
      if (cnt == ONE) pending <= 1'b0;
      else            cnt     <= cnt - ONE;
    end
  end

  assign fire.strobe = (evt.strobe && zero_load) || expire;
  assign fire.level  = evt.strobe ? evt.level : tgt;
endmodule

// File: rtl/hbdb_leg.sv
module hbdb_leg
  import hbdb_pkg::*;
#(
  parameter logic ACT_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_evt_t evt,
  input  pwm_evt_t fire,
  output logic     drv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    drv <= 1'b0;
    else if (fire.strobe && fire.level == ACT_LEVEL) drv <= 1'b1;
    else if (evt.strobe && evt.level != ACT_LEVEL)   drv <= 1'b0;
  end
endmodule

// File: rtl/hbdb_gen.sv
module hbdb_gen
  import hbdb_pkg::*;
#(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             unit_tick,
  input  logic             dly_wr,
  input  logic [DLY_W-1:0] dly_wdata,
  output logic [DLY_W-1:0] dly_value,
  output logic             drv_high,
  output logic             drv_low
);
  pwm_evt_t        evt;
  pwm_evt_t        fire;
  logic [LEGS-1:0] drv;

  hbdb_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .evt    (evt)
  );

  hbdb_delay_cfg #(.DLY_W(DLY_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (dly_wr),
    .wdata (dly_wdata),
    .value (dly_value)
  );

  hbdb_dead_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .load_val (dly_value),
    .tick     (unit_tick),
    .fire     (fire)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hbdb_leg #(.ACT_LEVEL(leg_active_level(g))) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .fire  (fire),
      .drv   (drv[g])
    );
  end

  assign drv_high = drv[LEG_HIGH];
  assign drv_low  = drv[LEG_LOW];
endmodule

// File: rtl/hbdb_gen_chk.sv
module hbdb_gen_chk #(
  parameter int DLY_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_in,
  input logic             unit_tick,
  input logic             dly_wr,
  input logic [DLY_W-1:0] dly_wdata,
  input logic [DLY_W-1:0] dly_value,
  input logic             drv_high,
  input logic             drv_low
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!drv_high && !drv_low && dly_value == '0)
        else $error("outputs not idle in reset");
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_high && drv_low));

  assert_high_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |=> !drv_high);

  assert_low_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_in |=> !drv_low);

  assert_high_on_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_high) |-> ($past(pwm_in) && ($past(unit_tick) || $past(dly_value) == '0)));

  assert_low_on_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_low) |-> (!$past(pwm_in) && ($past(unit_tick) || $past(dly_value) == '0)));

  assert_dly_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dly_wr |=> (dly_value == $past(dly_wdata)));

  assert_dly_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_wr |=> $stable(dly_value));
endmodule

bind hbdb_gen hbdb_gen_chk #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_in    (pwm_in),
  .unit_tick (unit_tick),
  .dly_wr    (dly_wr),
  .dly_wdata (dly_wdata),
  .dly_value (dly_value),
  .drv_high  (drv_high),
  .drv_low   (drv_low)
);

// File: tb/tb_hbdb_gen.sv
module tb_hbdb_gen;
  localparam int DLY_W = 7;
  localparam int UNIT  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwm_in = 1'b0;
  logic             unit_tick = 1'b0;
  logic             dly_wr = 1'b0;
  logic [DLY_W-1:0] dly_wdata = '0;
  logic [DLY_W-1:0] dly_value;
  logic             drv_high;
  logic             drv_low;

  hbdb_gen #(.DLY_W(DLY_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_in    (pwm_in),
    .unit_tick (unit_tick),
    .dly_wr    (dly_wr),
    .dly_wdata (dly_wdata),
    .dly_value (dly_value),
    .drv_high  (drv_high),
    .drv_low   (drv_low)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Tick sampled high on every edge where cyc becomes a multiple of UNIT.
  always @(negedge clk) unit_tick <= ((cyc + 1) % UNIT == 0);

  typedef struct {
    logic  hi;
    logic  lo;
    int    at;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0;
  int   n_errors = 0;
  logic last_hi = 1'b0, last_lo = 1'b0;
  logic prev_hi = 1'b0, prev_lo = 1'b0;
  int   cur_d = 0;
  bit   done = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic void expect_state(logic hi, logic lo, int at, string tag);
    if (hi == last_hi && lo == last_lo) return;
    expq.push_back('{hi, lo, at, tag});
    last_hi = hi;
    last_lo = lo;
  endfunction

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(!(drv_high && drv_low), "R2", "both drives active", 1, 0);
      if (drv_high != prev_hi || drv_low != prev_lo) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3", "unexpected output change {hi,lo}", int'({drv_high, drv_low}), -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(e.hi == drv_high && e.lo == drv_low, e.tag, "output pair {hi,lo}",
                int'({drv_high, drv_low}), int'({e.hi, e.lo}));
          check(e.at == cyc, e.tag, "cycle of output change", cyc, e.at);
        end
        prev_hi = drv_high;
        prev_lo = drv_low;
      end
    end
  end

  task automatic wr_delay(int d);
    dly_wr    = 1'b1;
    dly_wdata = DLY_W'(d);
    @(negedge clk);
    dly_wr = 1'b0;
    cur_d  = d;
    check(dly_value == DLY_W'(d), "R9", "dly_value after write", int'(dly_value), d);
  endtask

  // Drive one PWM level, aligned so the transition edge is a tick edge.
  task automatic apply(logic v, int hold, string tag, bit do_wr = 1'b0, int wr_val = 0);
    int n;
    int d_now;
    while (((cyc + 1) % UNIT) != 0) @(negedge clk);
    n      = cyc;
    d_now  = cur_d;
    pwm_in = v;
    if (d_now == 0) begin
      expect_state(v, !v, n + 1, {tag, " R6"});
    end else begin
      expect_state(1'b0, 1'b0, n + 1, "R3");
      if (hold > d_now) expect_state(v, !v, n + 1 + UNIT * d_now, {tag, " R4 R5"});
    end
    if (do_wr) begin
      @(negedge clk);
      @(negedge clk);
      dly_wr    = 1'b1;
      dly_wdata = DLY_W'(wr_val);
      @(negedge clk);
      dly_wr = 1'b0;
      cur_d  = wr_val;
      check(dly_value == DLY_W'(wr_val), "R8", "dly_value after mid-count write",
            int'(dly_value), wr_val);
    end
    while (cyc < n + UNIT * hold) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle during reset.
    check(drv_high == 1'b0, "R1", "drv_high in reset", int'(drv_high), 0);
    check(drv_low == 1'b0, "R1", "drv_low in reset", int'(drv_low), 0);
    check(dly_value == '0, "R1", "dly_value in reset", int'(dly_value), 0);
    // R1 with R6: first edge after release acts on pwm_in=0 with zero delay.
    expect_state(1'b0, 1'b1, 1, "R1 R6");
    rst_n = 1'b1;
    @(negedge clk);

    // R6: zero delay gives direct complements.
    apply(1'b1, 3, "R6");
    apply(1'b0, 3, "R6");

    // R9: data change without strobe is ignored.
    dly_wdata = 7'd99;
    @(negedge clk);
    @(negedge clk);
    check(dly_value == '0, "R9", "dly_value without strobe", int'(dly_value), 0);

    // R4 R5: two-unit delay.
    wr_delay(2);
    apply(1'b1, 5, "R4");
    apply(1'b0, 5, "R4");

    // R7: cancel before expiry, and transition on the expiring edge.
    apply(1'b1, 1, "R7");
    apply(1'b0, 6, "R7");
    apply(1'b1, 2, "R7");
    apply(1'b0, 4, "R7");

    // R8: write during a running count applies from the next transition.
    apply(1'b1, 6, "R8", 1'b1, 5);
    apply(1'b0, 8, "R8");

    // R4: largest delay, then a short hold that cancels it (R7).
    wr_delay(127);
    apply(1'b1, 130, "R4");
    apply(1'b0, 3, "R7");

    // R4: smallest nonzero delay.
    wr_delay(1);
    apply(1'b1, 2, "R4");
    apply(1'b0, 2, "R4");
    apply(1'b1, 3, "R4");

    repeat (40) @(negedge clk);
    check(expq.size() == 0, "R4", "expected changes left unseen", expq.size(), 0);
    finish_run();
  end
endmodule